// File: doc/BRIEF.md
# Chained-Register Multiplexed Display Scanner

The block refreshes a four-digit, seven-segment common-cathode display. The display is driven by two external serial-in driver registers that are wired in a chain. The scanner toggles one data line and one clock line to shift a 16-bit frame through both registers. It then pulses a separate strobe, which copies the frame onto the driver outputs. A fourth line enables the segment drivers, and the time it stays high in each slot sets the brightness. The digits are lit one at a time in a fixed rotation.

The digit-select register has three spare outputs, and each of them feeds one push-button. After the four digit slots, the scanner runs three probe slots. In each probe slot one spare output is asserted and all segments are off. The scanner then reads the shared serial return line, which is pulled up. A low level on that line means the probed button is closed. Each reading passes through a debounce filter before it reaches the button outputs.

Top module: `disp_scan_chain`

## Requirements
- R1: Every slot shifts exactly one 16-bit frame, most significant bit first. The first eight bits are the segment byte, sent from the decimal point (bit 7) down to segment a (bit 0). The last eight bits are the digit-select byte, in which bit k drives select output k. After all 16 shifts, the segment byte has passed through the select register and sits in the segment register.
- R2: The serial clock runs at one quarter of the system clock, with two clocks low and then two clocks high. The data line is updated only while the serial clock is low. Each slot contains exactly 16 rising edges.
- R3: The strobe is high for exactly one system clock and occurs once per slot, every SLOT_CLKS (1024) clocks. While the strobe is high, both the enable line and the serial clock are low.
- R4: The select byte has exactly one bit set, and bit 7 is never set. The latched frames cycle through select outputs 0, 1, 2, 3, 4, 5, 6 and then repeat from 0.
- R5: In a digit slot, the enable line goes high right after the strobe and stays high for brightness × 4 clocks. A brightness of 0 keeps the enable line low for the whole slot.
- R6: During the probe slots on outputs 4, 5 and 6, the segment byte is all zero and the enable line stays low.
- R7: The line is sampled near the end of each probe slot, and a low level counts as pressed. A button output (bit b for select output 4+b, where 1 means pressed) changes only after the same new reading has been seen on 4 consecutive scan passes.
- R8: While reset is active, all outputs are low and every button reads released. The enable line also stays low until the first frame after reset has been latched, and that first frame selects output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_pattern | input | 32 | Segment byte for digit d at bits 8d+7..8d |
| brightness | input | 8 | Enable on-time in steps of 4 clocks |
| chain_in | input | 1 | Shared serial return line with pull-up (low means the probed button is pressed) |
| chain_data | output | 1 | Serial data into the select register |
| chain_clk | output | 1 | Bit-toggled serial clock |
| chain_latch | output | 1 | Strobe that copies the frame to the driver outputs |
| seg_enable | output | 1 | Segment driver enable |
| buttons | output | 3 | Debounced button states |

## Verification
The next frame is shifted into the chain while the current digit is still lit. With a large brightness value, the serial clock and the enable line are therefore both high in the same cycles. The bench keeps its own copy of both external registers and drives the input vectors with brightness values 0, 37 and 255. It then checks three things: that every latched frame is exact, that the 16 clock edges land inside each slot, and that the enable count between two strobes matches brightness × 4. A second overlap happens when a probe reading changes a button state in the cycles just before a strobe. That case is judged by checking the button outputs after press patterns that are shorter and longer than four passes.

// File: rtl/disp_scan_chain.sv
module disp_scan_chain #(
  parameter int SLOT_CLKS  = 1024,
  parameter int BRIGHT_W   = 8,
  parameter int ON_SHIFT   = 2,
  parameter int SCK_LOG    = 2,
  parameter int DEB_PASSES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         seg_pattern,
  input  logic [BRIGHT_W-1:0] brightness,
  input  logic                chain_in,
  output logic                chain_data,
  output logic                chain_clk,
  output logic                chain_latch,
  output logic                seg_enable,
  output logic [2:0]          buttons
);
  localparam int NDIG      = 4;
  localparam int NBTN      = 3;
  localparam int NSTEP     = NDIG + NBTN;
  localparam int FW        = 16;
  localparam int CW        = $clog2(SLOT_CLKS);
  localparam int SW        = $clog2(NSTEP);
  localparam int DW        = $clog2(DEB_PASSES);
  localparam int SHIFT_LEN = FW << SCK_LOG;

  logic [CW-1:0] cnt, idx;
  logic [SW-1:0] step, step_nx;
  logic [FW-1:0] frm;
  logic [7:0]    nseg, ndig;
  logic [3:0]    bnum;
  logic [CW:0]   on_lim;
  logic [1:0]    sync, bsel;
  logic          primed, in_win, sample_now, rd_pressed;
  logic [DW-1:0] dcnt [NBTN];

  assign step_nx    = (step == SW'(NSTEP - 1)) ? '0 : step + 1'b1;
  assign nseg       = (step_nx < SW'(NDIG)) ? seg_pattern[{step_nx[1:0], 3'b000} +: 8] : 8'h00;
  assign ndig       = 8'd1 << step_nx;
  assign idx        = cnt - 1'b1;
  assign in_win     = (cnt != '0) && (cnt <= CW'(SHIFT_LEN));
  assign bnum       = idx[SCK_LOG +: 4];
  assign on_lim     = (CW+1)'(brightness) << ON_SHIFT;
  assign bsel       = 2'(step - SW'(NDIG));
  assign sample_now = primed && (step >= SW'(NDIG)) && (cnt == CW'(SLOT_CLKS - 3));
  assign rd_pressed = ~sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      step        <= SW'(NSTEP - 1);
      frm         <= '0;
      primed      <= 1'b0;
      chain_data  <= 1'b0;
      chain_clk   <= 1'b0;
      chain_latch <= 1'b0;
      seg_enable  <= 1'b0;
      sync        <= 2'b11;
    end else begin
      cnt <= (cnt == CW'(SLOT_CLKS - 1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(SLOT_CLKS - 1)) step <= step_nx;
      if (cnt == '0) frm <= {nseg, ndig};
      chain_data  <= in_win & frm[4'd15 - bnum];
      chain_clk   <= in_win & idx[SCK_LOG-1];
      chain_latch <= (cnt == CW'(SLOT_CLKS - 2));
      if (cnt == CW'(SLOT_CLKS - 2)) primed <= 1'b1;
      seg_enable  <= primed && (step < SW'(NDIG)) && ({1'b0, cnt} < on_lim);
      sync        <= {sync[0], chain_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buttons <= '0;
      for (int b = 0; b < NBTN; b++) dcnt[b] <= '0;
    end else begin
      for (int b = 0; b < NBTN; b++) begin
        if (sample_now && bsel == 2'(b)) begin
          if (rd_pressed == buttons[b]) begin
            dcnt[b] <= '0;
          end else if (dcnt[b] == DW'(DEB_PASSES - 1)) begin
            buttons[b] <= rd_pressed;
            dcnt[b]    <= '0;
          end else begin
            dcnt[b] <= dcnt[b] + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/disp_scan_chain_chk.sv
module disp_scan_chain_chk #(
  parameter int SLOT_CLKS = 1024
) (
  input logic       clk,
  input logic       rst_n,
  input logic       chain_clk,
  input logic       chain_latch,
  input logic       seg_enable,
  input logic [2:0] buttons
);
  logic seen;
  int   since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      since <= 0;
    end else begin
      if (chain_latch) seen <= 1'b1;
      since <= chain_latch ? 0 : since + 1;
    end
  end

  AST_STROBE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    chain_latch |-> (!seg_enable && !chain_clk)); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chain_latch |=> !chain_latch); // R3
  AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_latch && seen) |-> (since == SLOT_CLKS - 1)); // R3
  AST_BTN_CHANGE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buttons) |-> !seg_enable); // R7
  AST_DARK_UNTIL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !seg_enable); // R8
endmodule

bind disp_scan_chain disp_scan_chain_chk #(.SLOT_CLKS(SLOT_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_clk(chain_clk), .chain_latch(chain_latch),
  .seg_enable(seg_enable), .buttons(buttons)
);

// File: tb/tb_disp_scan_chain.sv
module tb_disp_scan_chain;
  localparam int SLOT = 1024;
  localparam int PASS = 7 * SLOT;
  localparam logic [39:0] VEC [3] = '{
    {8'd37,  32'h3F06_5B4F},
    {8'd0,   32'hFF00_A55A},
    {8'd255, 32'h807F_01FE}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] seg_pattern;
  logic [7:0]  brightness;
  logic        chain_in, chain_data, chain_clk, chain_latch, seg_enable;
  logic [2:0]  buttons;

  logic [15:0] sr = '0;
  logic [7:0]  lat_dig = '0;
  logic [2:0]  pressed = '0;
  logic        p_sclk = 1'b0, mon_on = 1'b1, done = 1'b0;
  int checks = 0, errors = 0, cyc = 0, en_cnt = 0, rises = 0, prev_st = 7;

  always #4 clk = ~clk;
  assign chain_in = ~|(lat_dig[6:4] & pressed);

  disp_scan_chain dut (
    .clk(clk), .rst_n(rst_n), .seg_pattern(seg_pattern), .brightness(brightness),
    .chain_in(chain_in), .chain_data(chain_data), .chain_clk(chain_clk),
    .chain_latch(chain_latch), .seg_enable(seg_enable), .buttons(buttons)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_pass(input int n);
    repeat (n * PASS) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int est, exp_en;
      logic [7:0] exp_seg;
      cyc++;
      en_cnt += int'(seg_enable);
      if (chain_clk && !p_sclk) begin
        sr = {sr[14:0], chain_data};
        rises++;
      end
      p_sclk = chain_clk;
      if (chain_latch) begin
        est     = (prev_st >= 6) ? 0 : prev_st + 1;
        exp_seg = (est < 4) ? seg_pattern[8*est +: 8] : 8'h00;
        exp_en  = (prev_st < 4) ? int'(brightness) * 4 : 0;
        if (mon_on) begin
          chk(sr[7:0] == (8'd1 << est), "R4 select byte", sr[7:0], 8'd1 << est);
          chk(sr[15:8] == exp_seg, (est < 4) ? "R1 segment byte" : "R6 probe segments blank", sr[15:8], exp_seg);
          chk(rises == 16, "R2 clock edges per slot", rises, 16);
          chk(!seg_enable && !chain_clk, "R3 strobe while dark", {seg_enable, chain_clk}, 0);
          if (prev_st != 7) chk(cyc == SLOT, "R3 strobe period", cyc, SLOT);
          chk(en_cnt == exp_en,
              (prev_st == 7) ? "R8 dark before first frame" : (prev_st < 4) ? "R5 on-time" : "R6 probe dark",
              en_cnt, exp_en);
        end
        lat_dig = sr[7:0];
        prev_st = est;
        cyc = 0; en_cnt = 0; rises = 0;
      end
    end
  end

  initial begin
    repeat (198000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    {brightness, seg_pattern} = VEC[0];
    repeat (4) @(negedge clk);
    chk({chain_data, chain_clk, chain_latch, seg_enable, buttons} == '0, "R8 reset outputs",
        {chain_data, chain_clk, chain_latch, seg_enable, buttons}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!seg_enable && buttons == 3'b000, "R8 after reset", {seg_enable, buttons}, 0);

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      mon_on = 1'b0;
      {brightness, seg_pattern} = VEC[i];
      wait_pass(1);
      mon_on = 1'b1;
      wait_pass(1);
    end
    chk(buttons == 3'b000, "R7 idle released", buttons, 0);

    pressed = 3'b010;
    wait_pass(2);
    chk(buttons == 3'b000, "R7 not yet four passes", buttons, 0);
    wait_pass(3);
    chk(buttons == 3'b010, "R7 accepted press", buttons, 3'b010);

    pressed = 3'b011;
    wait_pass(2);
    pressed = 3'b010;
    wait_pass(3);
    chk(buttons == 3'b010, "R7 short press ignored", buttons, 3'b010);

    pressed = 3'b100;
    wait_pass(5);
    chk(buttons == 3'b100, "R7 release and new press", buttons, 3'b100);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule